// File: doc/BRIEF.md
# Link Synchronization Request Monitor

This block sits on the transmit side of a serial converter link and watches the active-low synchronization line returned by the receiver. It runs in the link clock domain, where each clock carries four octets. Every low pulse is timed. A long pulse means the receiver wants the link restarted. The block then raises a one-cycle restart strobe for the link sequencer, which sends it back into code group synchronization. A short pulse ending while the link runs is treated as an error report. Both events set sticky status bits that software clears by writing ones. Each status bit has its own interrupt enable.

In subclass 2 operation the block also measures where the line deasserts relative to the local multiframe counter. It latches three fields: a misalignment flag, the direction of the shorter move to the nearest multiframe tick, and the number of link-clock steps. Software reads these fields to plan the adjustment. The input line passes through a two-flop synchronizer before any timing is done on it.

Top module: `sync_req_monitor`

## Requirements
- R1: After reset both status bits are 0, both interrupt enables are 1, `irq` is 0, `sync_live` is 1, and the three phase fields are 0.
- R2: `sync_live` follows `sync_n_in` two clock edges later. A value of 0 means the receiver is requesting synchronization.
- R3: The low duration is counted at 4 octets per link clock. With `link_active` high, once it exceeds 5*FRAME_OCTETS+9 octets, `st_reinit` is set and `reinit_pulse` goes high for exactly one cycle, once per pulse. With the default FRAME_OCTETS=2 this happens on the fifth consecutive low cycle.
- R4: A pulse that ends before reaching the R3 threshold, with `link_active` high, sets `st_err`.
- R5: While `link_active` is low, low pulses of any length set neither status bit and produce no `reinit_pulse`.
- R6: Status bits are write-1-to-clear. When `clr_wr` is high, bit 0 of `clr_mask` clears `st_err` and bit 1 clears `st_reinit`. A bit that is not cleared holds its value. A set in the same cycle wins over the clear.
- R7: When `ien_wr` is high, `ien_data` loads the enables: bit 0 enables `st_err` and bit 1 enables `st_reinit`. `irq` is the OR of each status bit ANDed with its enable.
- R8: When `sc2_mode` is high and a deassertion (rising `sync_live`) is detected, the phase is taken from the `lmfc_cnt` value in that cycle. `ph_misalign` becomes 1 exactly when `lmfc_cnt` is not 0.
- R9: If `lmfc_cnt` <= LMFC_CYCLES/2, `ph_dir` is 0 (advance) and `ph_steps` equals `lmfc_cnt`. Otherwise `ph_dir` is 1 (delay) and `ph_steps` equals LMFC_CYCLES - `lmfc_cnt`. `ph_steps` is 8 bits wide.
- R10: The phase fields hold their values until the next deassertion detected with `sc2_mode` high. Deassertions detected with `sc2_mode` low leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_n_in | input | 1 | Asynchronous receiver synchronization line, active low |
| link_active | input | 1 | High while the link is running |
| sc2_mode | input | 1 | Enables the subclass 2 phase measurement |
| lmfc_cnt | input | $clog2(LMFC_CYCLES) | Local multiframe counter value |
| clr_wr | input | 1 | Write strobe for clearing status bits |
| clr_mask | input | 2 | Bits to clear: bit 0 is the error, bit 1 is the request |
| ien_wr | input | 1 | Write strobe for the interrupt enables |
| ien_data | input | 2 | New enable values, same bit order as clr_mask |
| sync_live | output | 1 | Synchronized line value |
| st_err | output | 1 | Sticky error-report status |
| st_reinit | output | 1 | Sticky restart-request status |
| reinit_pulse | output | 1 | One-cycle restart strobe to the sequencer |
| irq | output | 1 | Interrupt request |
| ph_misalign | output | 1 | Deassertion was off the multiframe tick |
| ph_dir | output | 1 | 0 advance, 1 delay |
| ph_steps | output | 8 | Link-clock steps to the nearest tick |

## Verification
The checker confirms on every cycle that:
- the restart strobe never lasts two cycles and is always followed by a set request bit;
- status bits stay set unless cleared;
- the interrupt never rises without a status bit;
- the phase fields stay still while the line is low;
- the step count never exceeds half a multiframe, and an aligned result carries zero steps and advance direction.

Only the bench's scenarios can show the rest. These scenarios mix random pulse lengths, link states, modes and counter phases with directed edge lengths on both sides of the threshold. They cover the classification by pulse length, the ignore-when-idle rule, the exact phase values, and the masking of the interrupt.

// File: rtl/sync_req_monitor.sv
module sync_req_monitor #(
  parameter int FRAME_OCTETS = 2,
  parameter int LMFC_CYCLES  = 8,
  localparam int LMFC_W      = $clog2(LMFC_CYCLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_n_in,
  input  logic              link_active,
  input  logic              sc2_mode,
  input  logic [LMFC_W-1:0] lmfc_cnt,
  input  logic              clr_wr,
  input  logic [1:0]        clr_mask,
  input  logic              ien_wr,
  input  logic [1:0]        ien_data,
  output logic              sync_live,
  output logic              st_err,
  output logic              st_reinit,
  output logic              reinit_pulse,
  output logic              irq,
  output logic              ph_misalign,
  output logic              ph_dir,
  output logic [7:0]        ph_steps
);
  localparam int LIMIT_OCT = 5 * FRAME_OCTETS + 9;
  localparam int REQ_CYC   = LIMIT_OCT / 4 + 1;
  localparam int CNT_W     = $clog2(REQ_CYC + 1);
  localparam logic [CNT_W-1:0] REQ_TOP = CNT_W'(REQ_CYC);
  localparam logic [CNT_W-1:0] REQ_HIT = CNT_W'(REQ_CYC - 1);
  localparam logic [7:0] HALF  = 8'(LMFC_CYCLES / 2);
  localparam logic [7:0] FULL  = 8'(LMFC_CYCLES);

  logic             s1, s2, s3;
  logic [CNT_W-1:0] low_cnt;
  logic [1:0]       ien;
  logic             rise, req_hit, err_hit;
  logic [7:0]       fwd;

  always_ff @(posedge clk) begin
    if (!rst_n) {s1, s2, s3} <= 3'b111;
    else        {s1, s2, s3} <= {sync_n_in, s1, s2};
  end

  assign sync_live = s2;
  assign rise      = s2 & ~s3;

  always_ff @(posedge clk) begin
    if (!rst_n || s2)         low_cnt <= '0;
    else if (low_cnt != REQ_TOP) low_cnt <= low_cnt + 1'b1;
  end

  assign req_hit = link_active & ~s2 & (low_cnt == REQ_HIT);
  assign err_hit = link_active & rise & (low_cnt < REQ_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_err       <= 1'b0;
      st_reinit    <= 1'b0;
      reinit_pulse <= 1'b0;
      ien          <= 2'b11;
    end else begin
      st_err       <= err_hit | (st_err    & ~(clr_wr & clr_mask[0]));
      st_reinit    <= req_hit | (st_reinit & ~(clr_wr & clr_mask[1]));
      reinit_pulse <= req_hit;
      if (ien_wr) ien <= ien_data;
    end
  end

  assign irq = (st_err & ien[0]) | (st_reinit & ien[1]);

  assign fwd = 8'(lmfc_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_misalign <= 1'b0;
      ph_dir      <= 1'b0;
      ph_steps    <= '0;
    end else if (sc2_mode && rise) begin
      ph_misalign <= (fwd != 8'd0);
      ph_dir      <= (fwd > HALF);
      ph_steps    <= (fwd > HALF) ? (FULL - fwd) : fwd;
    end
  end
endmodule

// File: rtl/sync_req_monitor_chk.sv
module sync_req_monitor_chk #(
  parameter int LMFC_CYCLES = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       clr_wr,
  input logic [1:0] clr_mask,
  input logic       sync_live,
  input logic       st_err,
  input logic       st_reinit,
  input logic       reinit_pulse,
  input logic       irq,
  input logic       ph_misalign,
  input logic       ph_dir,
  input logic [7:0] ph_steps
);
  localparam logic [7:0] HALF = 8'(LMFC_CYCLES / 2);

  // R3
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_pulse |=> !reinit_pulse);

  // R3
  strobe_sets_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_pulse |-> st_reinit);

  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_err && !(clr_wr && clr_mask[0])) |=> st_err);

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_reinit && !(clr_wr && clr_mask[1])) |=> st_reinit);

  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st_err || st_reinit));

  // R10
  phase_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_live |=> ($stable(ph_steps) && $stable(ph_dir) && $stable(ph_misalign)));

  // R9
  steps_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_steps <= HALF);

  // R8
  aligned_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_misalign |-> (ph_steps == 8'd0 && !ph_dir));
endmodule

bind sync_req_monitor sync_req_monitor_chk #(.LMFC_CYCLES(LMFC_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_wr(clr_wr), .clr_mask(clr_mask),
  .sync_live(sync_live), .st_err(st_err), .st_reinit(st_reinit),
  .reinit_pulse(reinit_pulse), .irq(irq), .ph_misalign(ph_misalign),
  .ph_dir(ph_dir), .ph_steps(ph_steps)
);

// File: tb/sim_sync_req_monitor.sv
`timescale 1ns/1ps
module sim_sync_req_monitor;
  localparam int F     = 2;
  localparam int LMFC  = 8;
  localparam int REQ_N = (5 * F + 9) / 4 + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_n_in = 1'b1, link_active = 1'b0, sc2_mode = 1'b0;
  logic [2:0] lmfc_cnt = '0;
  logic       clr_wr = 1'b0, ien_wr = 1'b0;
  logic [1:0] clr_mask = '0, ien_data = 2'b11;
  logic       sync_live, st_err, st_reinit, reinit_pulse, irq, ph_misalign, ph_dir;
  logic [7:0] ph_steps;

  int errors = 0, checks = 0, strobes = 0;
  logic [1:0] ien_m = 2'b11;
  logic       ex_mis = 0, ex_dir = 0;
  int         ex_steps = 0;

  always #2.5 clk = ~clk;

  sync_req_monitor #(.FRAME_OCTETS(F), .LMFC_CYCLES(LMFC)) u0 (
    .clk(clk), .rst_n(rst_n), .sync_n_in(sync_n_in), .link_active(link_active),
    .sc2_mode(sc2_mode), .lmfc_cnt(lmfc_cnt), .clr_wr(clr_wr), .clr_mask(clr_mask),
    .ien_wr(ien_wr), .ien_data(ien_data), .sync_live(sync_live), .st_err(st_err),
    .st_reinit(st_reinit), .reinit_pulse(reinit_pulse), .irq(irq),
    .ph_misalign(ph_misalign), .ph_dir(ph_dir), .ph_steps(ph_steps)
  );

  always @(negedge clk) if (rst_n && reinit_pulse) strobes++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_dir(int l);
    return (l > LMFC / 2) ? 1 : 0;
  endfunction

  function automatic int exp_steps(int l);
    return (l > LMFC / 2) ? LMFC - l : l;
  endfunction

  task automatic pulse(int n, bit act, bit sc2, int l);
    int s0 = strobes;
    bit e_req = act && n >= REQ_N;
    bit e_err = act && n < REQ_N;
    @(negedge clk);
    link_active = act; sc2_mode = sc2; lmfc_cnt = 3'(l); sync_n_in = 1'b0;
    repeat (n) @(negedge clk);
    sync_n_in = 1'b1;
    repeat (5) @(negedge clk);
    if (sc2) begin
      ex_mis = (l != 0); ex_dir = exp_dir(l); ex_steps = exp_steps(l);
    end
    chk(act ? "R3 request" : "R5 request ignored", st_reinit, e_req);
    chk(act ? "R4 error" : "R5 error ignored", st_err, e_err);
    chk("R3 strobe count", strobes - s0, e_req ? 1 : 0);
    chk("R7 irq", irq, (e_err & ien_m[0]) | (e_req & ien_m[1]));
    chk(sc2 ? "R8 misalign" : "R10 misalign held", ph_misalign, ex_mis);
    chk("R9 dir", ph_dir, ex_dir);
    chk("R9 steps", ph_steps, ex_steps);
  endtask

  task automatic clear(logic [1:0] m);
    clr_wr = 1'b1; clr_mask = m;
    @(negedge clk);
    clr_wr = 1'b0; clr_mask = '0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 st_err", st_err, 0);
    chk("R1 st_reinit", st_reinit, 0);
    chk("R1 irq", irq, 0);
    chk("R1 sync_live", sync_live, 1);
    chk("R1 phase", {ph_misalign, ph_dir, ph_steps}, 0);

    // R2 synchronizer delay
    sync_n_in = 1'b0;
    @(negedge clk);
    chk("R2 one edge", sync_live, 1);
    @(negedge clk);
    chk("R2 two edges", sync_live, 0);
    sync_n_in = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 released", sync_live, 1);
    chk("R5 idle link", st_err, 0);

    // R3 R4 boundary lengths
    pulse(REQ_N - 1, 1, 0, 0);
    clear(2'b11);
    chk("R6 clear err", st_err, 0);
    pulse(REQ_N, 1, 0, 0);
    clear(2'b01);
    chk("R6 partial clear keeps req", st_reinit, 1);
    clear(2'b10);
    chk("R6 clear req", st_reinit, 0);
    pulse(1, 1, 0, 0);
    clear(2'b11);

    // R7 masked request, enabled error
    ien_wr = 1'b1; ien_data = 2'b01; ien_m = 2'b01;
    @(negedge clk);
    ien_wr = 1'b0;
    pulse(REQ_N + 2, 1, 0, 0);
    chk("R7 masked request", irq, 0);
    clear(2'b11);
    pulse(2, 1, 0, 0);
    clear(2'b11);
    ien_wr = 1'b1; ien_data = 2'b11; ien_m = 2'b11;
    @(negedge clk);
    ien_wr = 1'b0;

    // R8 R9 directed phases: tie point and delay side
    pulse(3, 1, 1, LMFC / 2);
    clear(2'b11);
    pulse(3, 1, 1, LMFC - 1);
    clear(2'b11);
    pulse(6, 0, 0, 2);
    clear(2'b11);

    // random mix
    for (int i = 0; i < 60; i++) begin
      int n = 1 + int'($urandom % 9);
      bit a = ($urandom % 4) != 0;
      bit s = $urandom % 2;
      int l = int'($urandom % LMFC);
      pulse(n, a, s, l);
      clear(2'b11);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule